// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 memory out of power-up after a system reset. It walks a fixed list of seven steps: it releases the memory reset and enables on-die termination, raises the clock enable, writes the four mode registers in the order MR2, MR3, MR1, MR0, and then issues a long ZQ calibration. Between steps it holds the command slot idle for a cycle count given by parameters. When the last wait has run out it raises a done flag and leaves the command slot idle, so the main memory controller can take over.

The mode register words are built at elaboration from parameters: CAS latency, CAS write latency, write recovery, output drive strength, nominal termination and dynamic write termination. Several of these fields are split across address bits that are not next to each other. The MR1 word is also driven on an output, so that a later write-leveling stage can start from it. A configuration the block cannot encode stops the sequencer in an error state, and it then issues no command at all.

The command slot has one phase. It is made of active-low chip select, RAS, CAS and WE, a 14-bit address and a 3-bit bank address. Alongside the slot the block drives three level lines to the memory: clock enable, termination enable and an active-low memory reset.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst` is high, all four strobes are high, address and bank are zero, `mem_cke`, `mem_odt`, `mem_reset_n`, `init_done` and `init_error` are low.
- R2: With a legal configuration, the first clock edge after reset is released starts the steps. The order is: reset release, CKE raise, MR2 write, MR3 write, MR1 write, MR0 write, ZQ calibration.
- R3: The reset-release step raises `mem_reset_n` and `mem_odt` while `mem_cke` stays low. The next step raises `mem_cke`. All three then stay high.
- R4: Waits are counted from one step to the next. After reset release there are T_RESET idle cycles, after the CKE raise T_CKE, after MR0 T_MR0 and after ZQ T_ZQ. The MR2, MR3 and MR1 writes are followed at once by the next step, so a step with wait W is followed by the next step W+1 cycles later.
- R5: In every cycle that is not a mode register write or a ZQ calibration, all four strobes are high and address and bank are zero.
- R6: A mode register write is all four strobes low, with the bank equal to the register number. The MR0 word is composed as follows. A1:A0 are 00, for a burst length of 8. A8 is 1, for DLL reset. The CAS-latency code goes to A2 (code bit 0) and A6:A4 (code bits 3:1). CL 5 to 11 give code 2·(CL−4), and CL 12 to 14 give 2·(CL−12)+1. The write-recovery code goes to A11:A9: 16→0, 5..8→WR−4, 10/12/14→WR/2. For example, CL 11 and WR 8 give 0x970.
- R7: MR1 carries drive strength bit 0 at A1 and bit 1 at A5. It carries nominal termination bits 0, 1 and 2 at A2, A6 and A9, with all other bits zero. `mr1_value` always shows this word.
- R8: MR2 carries CWL−5 at A5:A3 and the dynamic write termination code at A10:A9. MR3 is written as zero.
- R9: ZQ calibration drives chip select and WE low, RAS and CAS high, address 0x400 and bank 0.
- R10: `init_done` rises in the cycle after the last ZQ wait cycle and stays high until reset. From then on the strobes stay idle and the three level lines stay high.
- R11: The configuration is rejected when CL is outside 5..14, WR is not one of the listed values, CWL is outside 5..12, the burst length is not 8, or a drive/termination value does not fit its field. On rejection, from the first edge after reset `init_error` is high. No command is issued, the level lines stay low and `init_done` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | 14 | Command address |
| cmd_bank | output | 3 | Bank address |
| mem_cke | output | 1 | Clock enable to memory |
| mem_odt | output | 1 | On-die termination enable |
| mem_reset_n | output | 1 | Memory reset, active low |
| init_done | output | 1 | Sequence complete, bus handed over |
| init_error | output | 1 | Configuration rejected |
| mr1_value | output | 14 | Composed MR1 word |

## Verification
The hardest things to reach from the ports are the rejection paths and the field positions that a single configuration leaves at zero. The parameters are fixed at elaboration, so no input stimulus can get there. The bench therefore places several instances side by side. The first uses the full default waits and checks the exact cycle gaps. The second uses short waits and a configuration that sets the other field bits (CL 12, WR 16, termination 5, drive 2). Three more are each illegal in one respect: CL, burst length or write recovery. Every instance is compared with a cycle-by-cycle model on every clock.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    localparam int ADDR_W = 14;
    localparam int BANK_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_WAIT,
        PH_DONE,
        PH_ERR
    } phase_e;

    typedef enum logic [2:0] {
        ST_RST_REL = 3'd0,
        ST_CKE_ON  = 3'd1,
        ST_MR2     = 3'd2,
        ST_MR3     = 3'd3,
        ST_MR1     = 3'd4,
        ST_MR0     = 3'd5,
        ST_ZQ      = 3'd6
    } step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    typedef struct packed {
        strobe_t             strobe;
        logic [ADDR_W-1:0]   addr;
        logic [BANK_W-1:0]   bank;
    } slot_t;

    typedef struct packed {
        logic       ok;
        logic [3:0] code;
    } enc4_t;

    localparam strobe_t STB_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam strobe_t STB_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam strobe_t STB_ZQ   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
    localparam logic [ADDR_W-1:0] ZQ_LONG_ADDR = ADDR_W'(14'h0400);

    // CAS latency to 4-bit mode code: two linear runs
    function automatic enc4_t cl_encode(int cl);
        enc4_t r;
        r = '0;
        if (cl >= 5 && cl <= 11) begin
            r.ok   = 1'b1;
            r.code = 4'((cl - 4) * 2);
        end else if (cl >= 12 && cl <= 14) begin
            r.ok   = 1'b1;
            r.code = 4'((cl - 12) * 2 + 1);
        end
        return r;
    endfunction

    // Write recovery to 3-bit mode code (held in low bits of code)
    function automatic enc4_t wr_encode(int wr);
        enc4_t r;
        r = '0;
        if (wr == 16) begin
            r.ok = 1'b1;
        end else if (wr >= 5 && wr <= 8) begin
            r.ok   = 1'b1;
            r.code = 4'(wr - 4);
        end else if (wr == 10 || wr == 12 || wr == 14) begin
            r.ok   = 1'b1;
            r.code = 4'(wr / 2);
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] mr0_compose(logic [3:0] clc, logic [2:0] wrc, logic dll_rst);
        logic [ADDR_W-1:0] w;
        w        = '0;
        w[2]     = clc[0];
        w[6:4]   = clc[3:1];
        w[8]     = dll_rst;
        w[11:9]  = wrc;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] mr1_compose(logic [1:0] drv, logic [2:0] rtt);
        logic [ADDR_W-1:0] w;
        w    = '0;
        w[1] = drv[0];
        w[5] = drv[1];
        w[2] = rtt[0];
        w[6] = rtt[1];
        w[9] = rtt[2];
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] mr2_compose(logic [2:0] cwl_off, logic [1:0] rtt_wr);
        logic [ADDR_W-1:0] w;
        w        = '0;
        w[5:3]   = cwl_off;
        w[10:9]  = rtt_wr;
        return w;
    endfunction

endpackage

// File: rtl/ddr3_mr_build.sv
module ddr3_mr_build
    import ddr3_init_pkg::*;
#(
    parameter int CL        = 11,
    parameter int CWL       = 8,
    parameter int WR        = 8,
    parameter int BURST_LEN = 8,
    parameter int DRIVE     = 1,
    parameter int RTT_NOM   = 1,
    parameter int RTT_WR    = 2
) (
    output logic [ADDR_W-1:0] mr0,
    output logic [ADDR_W-1:0] mr1,
    output logic [ADDR_W-1:0] mr2,
    output logic [ADDR_W-1:0] mr3,
    output logic              cfg_ok
);
    localparam enc4_t CL_ENC = cl_encode(CL);
    localparam enc4_t WR_ENC = wr_encode(WR);
    localparam bit CWL_OK    = (CWL >= 5) && (CWL <= 12);
    localparam bit FIELDS_OK = (DRIVE >= 0) && (DRIVE <= 3) &&
                               (RTT_NOM >= 0) && (RTT_NOM <= 7) &&
                               (RTT_WR >= 0) && (RTT_WR <= 3);
    localparam bit BL_OK     = (BURST_LEN == 8);
    localparam logic [2:0] CWL_OFF = CWL_OK ? 3'(CWL - 5) : 3'd0;

    always_comb begin
        mr0    = mr0_compose(CL_ENC.code, WR_ENC.code[2:0], 1'b1);
        mr1    = mr1_compose(2'(DRIVE), 3'(RTT_NOM));
        mr2    = mr2_compose(CWL_OFF, 2'(RTT_WR));
        mr3    = '0;
        cfg_ok = CL_ENC.ok && WR_ENC.ok && CWL_OK && FIELDS_OK && BL_OK;
    end
endmodule

// File: rtl/ddr3_wait_timer.sv
module ddr3_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr3_init_ctrl.sv
module ddr3_init_ctrl
    import ddr3_init_pkg::*;
#(
    parameter int T_RESET = 50000,
    parameter int T_CKE   = 10000,
    parameter int T_MR0   = 200,
    parameter int T_ZQ    = 200,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_ok,
    input  logic             wait_over,
    output phase_e           phase,
    output step_e            step,
    output logic             wait_load,
    output logic [CNT_W-1:0] wait_val
);
    logic [CNT_W-1:0] cur_wait;
    logic             has_wait;

    always_comb begin
        unique case (step)
            ST_RST_REL: cur_wait = CNT_W'(T_RESET);
            ST_CKE_ON:  cur_wait = CNT_W'(T_CKE);
            ST_MR0:     cur_wait = CNT_W'(T_MR0);
            ST_ZQ:      cur_wait = CNT_W'(T_ZQ);
            default:    cur_wait = '0;
        endcase
        has_wait  = (cur_wait != '0);
        wait_load = (phase == PH_ISSUE) && has_wait;
        wait_val  = cur_wait - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= ST_RST_REL;
        end else begin
            unique case (phase)
                PH_IDLE: phase <= cfg_ok ? PH_ISSUE : PH_ERR;
                PH_ISSUE, PH_WAIT: begin
                    if ((phase == PH_ISSUE && !has_wait) || (phase == PH_WAIT && wait_over)) begin
                        if (step == ST_ZQ) begin
                            phase <= PH_DONE;
                        end else begin
                            step  <= step_e'(step + 3'd1);
                            phase <= PH_ISSUE;
                        end
                    end else begin
                        phase <= PH_WAIT;
                    end
                end
                default: phase <= phase;
            endcase
        end
    end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
    import ddr3_init_pkg::*;
#(
    parameter int CL        = 11,
    parameter int CWL       = 8,
    parameter int WR        = 8,
    parameter int BURST_LEN = 8,
    parameter int DRIVE     = 1,
    parameter int RTT_NOM   = 1,
    parameter int RTT_WR    = 2,
    parameter int T_RESET   = 50000,
    parameter int T_CKE     = 10000,
    parameter int T_MR0     = 200,
    parameter int T_ZQ      = 200
) (
    input  logic        clk,
    input  logic        rst,
    output logic        cmd_cs_n,
    output logic        cmd_ras_n,
    output logic        cmd_cas_n,
    output logic        cmd_we_n,
    output logic [13:0] cmd_addr,
    output logic [2:0]  cmd_bank,
    output logic        mem_cke,
    output logic        mem_odt,
    output logic        mem_reset_n,
    output logic        init_done,
    output logic        init_error,
    output logic [13:0] mr1_value
);
    localparam int MAX_AB   = (T_RESET > T_CKE) ? T_RESET : T_CKE;
    localparam int MAX_CD   = (T_MR0 > T_ZQ) ? T_MR0 : T_ZQ;
    localparam int MAX_WAIT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int NEED_W   = $clog2(MAX_WAIT + 1);
    localparam int CNT_W    = (NEED_W > 16) ? NEED_W : 16;

    logic [ADDR_W-1:0] mr0, mr1, mr2, mr3;
    logic              cfg_ok;
    logic              wait_over;
    logic              wait_load;
    logic [CNT_W-1:0]  wait_val;
    phase_e            phase;
    step_e             step;
    slot_t             slot;
    logic              lvl_on, cke_on;

    ddr3_mr_build #(
        .CL(CL), .CWL(CWL), .WR(WR), .BURST_LEN(BURST_LEN),
        .DRIVE(DRIVE), .RTT_NOM(RTT_NOM), .RTT_WR(RTT_WR)
    ) u_mr (
        .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3), .cfg_ok(cfg_ok)
    );

    ddr3_init_ctrl #(
        .T_RESET(T_RESET), .T_CKE(T_CKE), .T_MR0(T_MR0), .T_ZQ(T_ZQ), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cfg_ok(cfg_ok), .wait_over(wait_over),
        .phase(phase), .step(step), .wait_load(wait_load), .wait_val(wait_val)
    );

    ddr3_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(wait_load), .load_val(wait_val), .expired(wait_over)
    );

    always_comb begin
        slot   = '{strobe: STB_IDLE, addr: '0, bank: '0};
        lvl_on = (phase == PH_ISSUE) || (phase == PH_WAIT) || (phase == PH_DONE);
        cke_on = (phase == PH_DONE) ||
                 (((phase == PH_ISSUE) || (phase == PH_WAIT)) && (step != ST_RST_REL));
        if (phase == PH_ISSUE) begin
            unique case (step)
                ST_MR2: slot = '{strobe: STB_MRS, addr: mr2, bank: BANK_W'(2)};
                ST_MR3: slot = '{strobe: STB_MRS, addr: mr3, bank: BANK_W'(3)};
                ST_MR1: slot = '{strobe: STB_MRS, addr: mr1, bank: BANK_W'(1)};
                ST_MR0: slot = '{strobe: STB_MRS, addr: mr0, bank: BANK_W'(0)};
                ST_ZQ:  slot = '{strobe: STB_ZQ,  addr: ZQ_LONG_ADDR, bank: '0};
                default: ;
            endcase
        end
    end

    assign cmd_cs_n    = slot.strobe.cs_n;
    assign cmd_ras_n   = slot.strobe.ras_n;
    assign cmd_cas_n   = slot.strobe.cas_n;
    assign cmd_we_n    = slot.strobe.we_n;
    assign cmd_addr    = slot.addr;
    assign cmd_bank    = slot.bank;
    assign mem_reset_n = lvl_on;
    assign mem_odt     = lvl_on;
    assign mem_cke     = cke_on;
    assign init_done   = (phase == PH_DONE);
    assign init_error  = (phase == PH_ERR);
    assign mr1_value   = mr1;
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_cs_n,
    input logic        cmd_ras_n,
    input logic        cmd_cas_n,
    input logic        cmd_we_n,
    input logic [13:0] cmd_addr,
    input logic [2:0]  cmd_bank,
    input logic        mem_cke,
    input logic        mem_odt,
    input logic        mem_reset_n,
    input logic        init_done,
    input logic        init_error
);
    p_idle_strobes_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_cs_n |-> (cmd_ras_n && cmd_cas_n && cmd_we_n && cmd_addr == '0 && cmd_bank == '0));

    p_cmd_after_cke_r3: assert property (@(posedge clk) disable iff (rst)
        !cmd_cs_n |-> (mem_cke && mem_reset_n && mem_odt));

    p_cke_after_reset_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cke) |-> (mem_reset_n && mem_odt && $past(mem_reset_n)));

    p_mr3_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmd_cs_n && !cmd_ras_n && cmd_bank == 3'd3) |-> (cmd_addr == '0));

    p_zq_shape_r9: assert property (@(posedge clk) disable iff (rst)
        (!cmd_cs_n && cmd_ras_n) |-> (cmd_cas_n && !cmd_we_n && cmd_addr == 14'h0400 && cmd_bank == '0));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_done_bus_free_r10: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd_cs_n && mem_cke && mem_odt && mem_reset_n));

    p_error_silent_r11: assert property (@(posedge clk) disable iff (rst)
        init_error |-> (cmd_cs_n && !mem_cke && !mem_reset_n && !init_done));
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk u_chk (
    .clk(clk), .rst(rst),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
    .mem_cke(mem_cke), .mem_odt(mem_odt), .mem_reset_n(mem_reset_n),
    .init_done(init_done), .init_error(init_error)
);

// File: tb/ddr3_pwrup_seq_bench.sv
module ddr3_pwrup_seq_bench;
    localparam int CLK_PERIOD = 10;
    // instance A: defaults
    localparam int AR = 50000, AC = 10000, AM = 200, AZ = 200;
    localparam logic [13:0] A_MR0 = 14'h0970, A_MR1 = 14'h0006, A_MR2 = 14'h0418;
    // instance B: short waits, other field values
    localparam int BR = 20, BC = 10, BM = 6, BZ = 5;
    localparam logic [13:0] B_MR0 = 14'h0104, B_MR1 = 14'h0224, B_MR2 = 14'h0210;
    localparam int LAST_E = 60450;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        cs_n[5], ras_n[5], cas_n[5], we_n[5], cke[5], odt[5], rstn[5], done[5], err[5];
    logic [13:0] addr[5], mr1v[5];
    logic [2:0]  bank[5];

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    int cmd_times[$];
    int cke_rise = -1, done_rise = -1;

    ddr3_pwrup_seq u_ddr3_pwrup_seq (
        .clk(clk), .rst(rst), .cmd_cs_n(cs_n[0]), .cmd_ras_n(ras_n[0]), .cmd_cas_n(cas_n[0]),
        .cmd_we_n(we_n[0]), .cmd_addr(addr[0]), .cmd_bank(bank[0]), .mem_cke(cke[0]),
        .mem_odt(odt[0]), .mem_reset_n(rstn[0]), .init_done(done[0]), .init_error(err[0]),
        .mr1_value(mr1v[0]));

    ddr3_pwrup_seq #(.CL(12), .CWL(7), .WR(16), .DRIVE(2), .RTT_NOM(5), .RTT_WR(1),
                     .T_RESET(BR), .T_CKE(BC), .T_MR0(BM), .T_ZQ(BZ)) u_short (
        .clk(clk), .rst(rst), .cmd_cs_n(cs_n[1]), .cmd_ras_n(ras_n[1]), .cmd_cas_n(cas_n[1]),
        .cmd_we_n(we_n[1]), .cmd_addr(addr[1]), .cmd_bank(bank[1]), .mem_cke(cke[1]),
        .mem_odt(odt[1]), .mem_reset_n(rstn[1]), .init_done(done[1]), .init_error(err[1]),
        .mr1_value(mr1v[1]));

    ddr3_pwrup_seq #(.CL(15), .T_RESET(4), .T_CKE(4), .T_MR0(2), .T_ZQ(2)) u_bad_cl (
        .clk(clk), .rst(rst), .cmd_cs_n(cs_n[2]), .cmd_ras_n(ras_n[2]), .cmd_cas_n(cas_n[2]),
        .cmd_we_n(we_n[2]), .cmd_addr(addr[2]), .cmd_bank(bank[2]), .mem_cke(cke[2]),
        .mem_odt(odt[2]), .mem_reset_n(rstn[2]), .init_done(done[2]), .init_error(err[2]),
        .mr1_value(mr1v[2]));

    ddr3_pwrup_seq #(.BURST_LEN(4), .T_RESET(4), .T_CKE(4), .T_MR0(2), .T_ZQ(2)) u_bad_bl (
        .clk(clk), .rst(rst), .cmd_cs_n(cs_n[3]), .cmd_ras_n(ras_n[3]), .cmd_cas_n(cas_n[3]),
        .cmd_we_n(we_n[3]), .cmd_addr(addr[3]), .cmd_bank(bank[3]), .mem_cke(cke[3]),
        .mem_odt(odt[3]), .mem_reset_n(rstn[3]), .init_done(done[3]), .init_error(err[3]),
        .mr1_value(mr1v[3]));

    ddr3_pwrup_seq #(.WR(9), .T_RESET(4), .T_CKE(4), .T_MR0(2), .T_ZQ(2)) u_bad_wr (
        .clk(clk), .rst(rst), .cmd_cs_n(cs_n[4]), .cmd_ras_n(ras_n[4]), .cmd_cas_n(cas_n[4]),
        .cmd_we_n(we_n[4]), .cmd_addr(addr[4]), .cmd_bank(bank[4]), .mem_cke(cke[4]),
        .mem_odt(odt[4]), .mem_reset_n(rstn[4]), .init_done(done[4]), .init_error(err[4]),
        .mr1_value(mr1v[4]));

    // observed vector: {cs,ras,cas,we, addr, bank, cke, odt, reset_n, done, err}
    function automatic logic [25:0] observe(int i);
        return {cs_n[i], ras_n[i], cas_n[i], we_n[i], addr[i], bank[i],
                cke[i], odt[i], rstn[i], done[i], err[i]};
    endfunction

    // behavioural model of a legal run, e = rising edges since reset release
    function automatic logic [25:0] model_ok(int e, int wr, int wc, int wm, int wz,
                                              logic [13:0] m0, logic [13:0] m1, logic [13:0] m2);
        int t_rel, t_cke, t_m2, t_m3, t_m1, t_m0, t_zq, t_done;
        logic [3:0]  s;
        logic [13:0] a;
        logic [2:0]  b;
        t_rel = 1; t_cke = t_rel + 1 + wr; t_m2 = t_cke + 1 + wc;
        t_m3 = t_m2 + 1; t_m1 = t_m3 + 1; t_m0 = t_m1 + 1;
        t_zq = t_m0 + 1 + wm; t_done = t_zq + 1 + wz;
        s = 4'b1111; a = '0; b = '0;
        if (e == t_m2)      begin s = 4'b0000; a = m2;      b = 3'd2; end
        else if (e == t_m3) begin s = 4'b0000; a = '0;      b = 3'd3; end
        else if (e == t_m1) begin s = 4'b0000; a = m1;      b = 3'd1; end
        else if (e == t_m0) begin s = 4'b0000; a = m0;      b = 3'd0; end
        else if (e == t_zq) begin s = 4'b0110; a = 14'h400; b = 3'd0; end
        return {s, a, b, (e >= t_cke && e > 0), (e >= t_rel), (e >= t_rel), (e >= t_done), 1'b0};
    endfunction

    function automatic string tag_ok(int e, int wr, int wc, int wm, int wz);
        int t_cke, t_m2, t_zq, t_done;
        t_cke = 2 + wr; t_m2 = t_cke + 1 + wc; t_zq = t_m2 + 4 + wm; t_done = t_zq + 1 + wz;
        if (e == 0) return "R1 reset state";
        if (e == 1 || e == t_cke) return "R3 level step";
        if (e == t_m2 || e == t_m2 + 1) return "R2 R8 MR2/MR3 write";
        if (e == t_m2 + 2) return "R2 R7 MR1 write";
        if (e == t_m2 + 3) return "R2 R6 MR0 write";
        if (e == t_zq) return "R2 R9 ZQ";
        if (e >= t_done) return "R10 done hold";
        return "R4 R5 idle wait";
    endfunction

    function automatic logic [25:0] model_err(int e);
        if (e == 0) return {4'b1111, 14'h0, 3'h0, 5'b00000};
        return {4'b1111, 14'h0, 3'h0, 5'b00001};
    endfunction

    task automatic check(string tag, string who, logic [25:0] act, logic [25:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s [%s]: actual %h expected %h", tag, who, act, exp_v);
        end
    endtask

    task automatic check_int(string tag, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int e = 0; e <= LAST_E; e++) begin
            if (e > 0) @(negedge clk);
            check(tag_ok(e, AR, AC, AM, AZ), "default", observe(0),
                  model_ok(e, AR, AC, AM, AZ, A_MR0, A_MR1, A_MR2));
            check(tag_ok(e, BR, BC, BM, BZ), "short", observe(1),
                  model_ok(e, BR, BC, BM, BZ, B_MR0, B_MR1, B_MR2));
            check(e == 0 ? "R1 reset state" : "R11 bad CL", "badcl", observe(2), model_err(e));
            check(e == 0 ? "R1 reset state" : "R11 bad BL", "badbl", observe(3), model_err(e));
            check(e == 0 ? "R1 reset state" : "R11 bad WR", "badwr", observe(4), model_err(e));
            if (e == 5) begin
                check("R7 mr1 output", "default", {12'h0, mr1v[0]}, {12'h0, A_MR1});
                check("R7 mr1 output", "short", {12'h0, mr1v[1]}, {12'h0, B_MR1});
            end
            if (e > 0 && !cs_n[0]) cmd_times.push_back(e);
            if (e > 0 && cke[0] && cke_rise < 0) cke_rise = e;
            if (e > 0 && done[0] && done_rise < 0) done_rise = e;
            if (e == 0) rst = 1'b0;
        end
        // R4: exact gaps between steps of the default instance
        check_int("R4 command count", cmd_times.size(), 5);
        if (cmd_times.size() == 5) begin
            check_int("R4 CKE to MR2 gap", cmd_times[0] - cke_rise, AC + 1);
            check_int("R4 MR2 to MR3 gap", cmd_times[1] - cmd_times[0], 1);
            check_int("R4 MR3 to MR1 gap", cmd_times[2] - cmd_times[1], 1);
            check_int("R4 MR1 to MR0 gap", cmd_times[3] - cmd_times[2], 1);
            check_int("R4 MR0 to ZQ gap", cmd_times[4] - cmd_times[3], AM + 1);
            check_int("R10 ZQ to done gap", done_rise - cmd_times[4], AZ + 1);
        end
        check_int("R4 release to CKE gap", cke_rise - 1, AR + 1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule